// File: doc/BRIEF.md
# I2C Arbitration Loss Injector

This block sits on the bus side of an I2C test setup and forces the master under test to lose arbitration. It is armed ahead of time with a window length counted in microseconds. It then watches the sampled SCL line. On the first falling SCL edge after arming, it turns on an open-drain pull on SDA and keeps it on for the programmed number of microsecond ticks. Address bits that the master sends as ones during that window are read back as zeros, and the master must report the lost arbitration.

A second mode leaves SDA alone. It counts the same programmed interval from the detected start of transfer and then emits a single-cycle trigger pulse, which can be used to disturb the master's controller in some other way. Every arming produces at most one event. The armed wait can be withdrawn before the SCL edge arrives. The microsecond time base comes from outside as a one-cycle tick strobe.

Top module: `arb_loss_inj`

## Requirements
- R1: After reset, `sda_pull_o`, `active_o` and `trig_o` are all 0.
- R2: After arming, the first falling edge on `scl_i` sets `sda_pull_o` and `active_o` to 1 on the third rising clock edge after `scl_i` goes low (two synchroniser stages plus one registered output), and not before.
- R3: With a window of N ≥ 1, `sda_pull_o` drops on the clock edge that consumes the N-th `us_tick_i` pulse counted after the pull started. Tick pulses that arrive while the block is only armed are not counted.
- R4: A requested window above MAX_US (100000) is clamped to 100000 ticks.
- R5: In pull mode (`trig_mode_i` = 0 at arming), a window of 0 gives no SDA pull and no `active_o` at the SCL edge, and the block disarms.
- R6: A `cancel_i` pulse while armed returns the block to idle, so a later SCL fall has no effect. `cancel_i` during a running window is ignored.
- R7: After one event the block is disarmed and a further SCL fall does nothing. An `arm_i` pulse while a window runs is ignored and does not change its length.
- R8: In trigger mode (`trig_mode_i` = 1 at arming) with delay N ≥ 1, `sda_pull_o` stays 0. `active_o` is 1 from the SCL edge on. On the edge that consumes the N-th tick, `trig_o` is 1 for exactly one cycle and `active_o` drops.
- R9: In trigger mode with delay 0, `trig_o` pulses for one cycle on the edge where a pull would have started, and `active_o` stays 0.
- R10: In pull mode, `active_o` is 1 exactly while `sda_pull_o` is 1.
- R11: Only a high-to-low transition counts as the start. If SCL is already low when the block is armed, it waits for SCL to rise and fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle strobe that arms the block when it is idle |
| cancel_i | input | 1 | Withdraws an armed, not yet started event |
| trig_mode_i | input | 1 | Mode latched at arming: 0 pulls SDA, 1 emits a trigger pulse |
| dur_us_i | input | 17 | Window length or trigger delay in microseconds, latched at arming |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| scl_i | input | 1 | Sampled SCL level (asynchronous) |
| sda_pull_o | output | 1 | 1 enables the open-drain pull of SDA low |
| trig_o | output | 1 | One-cycle trigger pulse in trigger mode |
| active_o | output | 1 | 1 while a window or delay is running |

## Verification
The bench aims at the edges of the tick count. A window that is one tick too long or too short shows up as a release that comes a cycle late or early. Tick pulses received while the block is only armed are also checked: a design that counted them would shorten the window. The synchroniser latency is checked at the cycle before and the cycle after the pull should appear. Arming while SCL is already low is covered, since a level-sensitive start would fire at once. The zero-length cases in both modes, cancel, re-arming and an arm strobe during a running window are each covered: a stale count, a missed disarm or a reloaded length all show up as wrong values at the outputs. The clamp is checked by counting a full 100000-cycle window under a continuous tick.

// File: rtl/arb_inj_pkg.sv
package arb_inj_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HOLD  = 2'd2,
        ST_WAIT  = 2'd3
    } inj_state_e;

endpackage

// File: rtl/arb_scl_sync.sv
module arb_scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic fall_o
);
    // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], scl_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;   // idle bus is high: no false edge out of reset
        else        chain_q <= chain_d;
    end

    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);  // R11

endmodule

// File: rtl/arb_us_timer.sv
module arb_us_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        done_o  = run_i && tick_i && (cnt_inc == {1'b0, limit_i});
        if (!run_i)      cnt_d = '0;
        else if (done_o) cnt_d = '0;
        else if (tick_i) cnt_d = cnt_inc[CNT_W-1:0];
        else             cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < limit_i));  // R3

endmodule

// File: rtl/arb_loss_inj.sv
module arb_loss_inj
    import arb_inj_pkg::*;
#(
    parameter int MAX_US      = 100000,
    parameter int DUR_W       = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             cancel_i,
    input  logic             trig_mode_i,
    input  logic [DUR_W-1:0] dur_us_i,
    input  logic             us_tick_i,
    input  logic             scl_i,
    output logic             sda_pull_o,
    output logic             trig_o,
    output logic             active_o
);
    localparam int          CNT_W  = $clog2(MAX_US + 1);
    localparam logic [31:0] MAX_U  = 32'(MAX_US);

    typedef struct packed {
        inj_state_e       st;
        logic             trig_mode;
        logic [CNT_W-1:0] lim;
        logic             pull;
        logic             act;
        logic             trig;
    } inj_regs_t;

    inj_regs_t        r_d, r_q;
    logic             scl_fall;
    logic             tmr_run;
    logic             tmr_done;
    logic [CNT_W-1:0] lim_clamped;

    arb_scl_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .fall_o(scl_fall)
    );

    assign tmr_run = (r_q.st == ST_HOLD) || (r_q.st == ST_WAIT);

    arb_us_timer #(.CNT_W(CNT_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (tmr_run),
        .tick_i (us_tick_i),
        .limit_i(r_q.lim),
        .done_o (tmr_done)
    );

    always_comb begin
        if (32'(dur_us_i) > MAX_U) lim_clamped = CNT_W'(MAX_US);
        else                       lim_clamped = CNT_W'(dur_us_i);
    end

    always_comb begin
        r_d      = r_q;
        r_d.trig = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (arm_i) begin
                    r_d.st        = ST_ARMED;
                    r_d.trig_mode = trig_mode_i;
                    r_d.lim       = lim_clamped;
                end
            end
            ST_ARMED: begin
                if (cancel_i) begin
                    r_d.st = ST_IDLE;
                end else if (scl_fall) begin
                    if (r_q.lim == '0) begin
                        r_d.st   = ST_IDLE;
                        r_d.trig = r_q.trig_mode;
                    end else begin
                        r_d.st   = r_q.trig_mode ? ST_WAIT : ST_HOLD;
                        r_d.act  = 1'b1;
                        r_d.pull = !r_q.trig_mode;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    r_d.st   = ST_IDLE;
                    r_d.pull = 1'b0;
                    r_d.act  = 1'b0;
                end
            end
            ST_WAIT: begin
                if (tmr_done) begin
                    r_d.st   = ST_IDLE;
                    r_d.act  = 1'b0;
                    r_d.trig = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.trig_mode <= 1'b0;
            r_q.lim       <= '0;
            r_q.pull      <= 1'b0;
            r_q.act       <= 1'b0;
            r_q.trig      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull_o = r_q.pull;
    assign active_o   = r_q.act;
    assign trig_o     = r_q.trig;

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);  // R8
    AST_CANCEL_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ARMED && cancel_i) |=> (r_q.st == ST_IDLE && !active_o));  // R6
    AST_PULL_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> ($past(r_q.st) == ST_ARMED));  // R2
    AST_NO_PULL_TRIG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) |-> !sda_pull_o);  // R8
    AST_ACTIVE_COVERS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> active_o);  // R10
    AST_HOLD_LIMIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD) |=> $stable(r_q.lim));  // R7

endmodule

// File: tb/arb_loss_inj_tb.sv
module arb_loss_inj_tb_top;

    localparam int MAX_US = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic        cancel_i = 1'b0;
    logic        trig_mode_i = 1'b0;
    logic [16:0] dur_us_i = '0;
    logic        us_tick_i = 1'b0;
    logic        scl_i = 1'b1;
    logic        sda_pull_o, trig_o, active_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int         at;
        logic [2:0] exp;   // {pull, active, trig}
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    sb_item_t cur;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    arb_loss_inj dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .cancel_i   (cancel_i),
        .trig_mode_i(trig_mode_i),
        .dur_us_i   (dur_us_i),
        .us_tick_i  (us_tick_i),
        .scl_i      (scl_i),
        .sda_pull_o (sda_pull_o),
        .trig_o     (trig_o),
        .active_o   (active_o)
    );

    task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {pull,active,trig} got=%b exp=%b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // monitor: pops expected items when their cycle arrives
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            cur = sb_q.pop_front();
            chk({sda_pull_o, active_o, trig_o}, cur.exp, cur.tag);
        end
    end

    task automatic exp_at(input int k, input logic [2:0] e, input string tag);
        sb_item_t it;
        it.at = cyc + k;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input logic [16:0] d, input logic m);
        arm_i = 1'b1; dur_us_i = d; trig_mode_i = m;
        step(1);
        arm_i = 1'b0;
    endtask

    task automatic pulse_tick();
        us_tick_i = 1'b1; step(1);
        us_tick_i = 1'b0; step(1);
    endtask

    task automatic scl_high();
        scl_i = 1'b1; step(4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got=timeout exp=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        step(1);
        chk({sda_pull_o, active_o, trig_o}, 3'b000, "R1 reset state");

        // R3/R2/R10: window of 3, ticks while armed ignored
        arm(17'd3, 1'b0);
        pulse_tick(); pulse_tick();
        scl_i = 1'b0;
        exp_at(2, 3'b000, "R2 no pull before sync latency");
        exp_at(3, 3'b110, "R2 pull after SCL fall");
        step(3);
        for (int i = 1; i <= 3; i++) begin
            exp_at(1, (i < 3) ? 3'b110 : 3'b000, "R3 R10 window tick count");
            pulse_tick();
        end
        // R7 one-shot: a second SCL fall does nothing
        scl_high();
        scl_i = 1'b0;
        exp_at(3, 3'b000, "R7 disarmed after event");
        exp_at(5, 3'b000, "R7 disarmed after event");
        step(6);

        // R7/R6: arm and cancel during a running window are ignored
        scl_high();
        arm(17'd2, 1'b0);
        scl_i = 1'b0;
        exp_at(3, 3'b110, "R2 pull start");
        step(3);
        exp_at(1, 3'b110, "R7 arm ignored while busy");
        arm(17'd50, 1'b1);
        cancel_i = 1'b1;
        exp_at(1, 3'b110, "R6 cancel ignored while running");
        step(1);
        cancel_i = 1'b0;
        exp_at(1, 3'b110, "R7 window unchanged");
        pulse_tick();
        exp_at(1, 3'b000, "R7 released after original length");
        pulse_tick();

        // R5: zero window in pull mode
        scl_high();
        arm(17'd0, 1'b0);
        scl_i = 1'b0;
        exp_at(3, 3'b000, "R5 zero window no pull");
        exp_at(4, 3'b000, "R5 zero window no pull");
        step(5);
        scl_high();
        scl_i = 1'b0;
        exp_at(3, 3'b000, "R5 disarmed after zero window");
        step(4);

        // R9: zero delay trigger
        scl_high();
        arm(17'd0, 1'b1);
        scl_i = 1'b0;
        exp_at(2, 3'b000, "R9 no trigger early");
        exp_at(3, 3'b001, "R9 immediate trigger");
        exp_at(4, 3'b000, "R9 trigger one cycle");
        step(5);

        // R8: trigger mode with delay 2
        scl_high();
        arm(17'd2, 1'b1);
        scl_i = 1'b0;
        exp_at(3, 3'b010, "R8 active without pull");
        step(3);
        exp_at(1, 3'b010, "R8 waiting");
        pulse_tick();
        exp_at(1, 3'b001, "R8 trigger fires");
        exp_at(2, 3'b000, "R8 trigger one cycle");
        pulse_tick();

        // R6: cancel before the edge
        scl_high();
        arm(17'd5, 1'b0);
        cancel_i = 1'b1; step(1); cancel_i = 1'b0;
        scl_i = 1'b0;
        exp_at(3, 3'b000, "R6 cancelled wait");
        exp_at(4, 3'b000, "R6 cancelled wait");
        step(5);

        // R11: armed while SCL already low
        arm(17'd1, 1'b0);
        exp_at(4, 3'b000, "R11 low level is not an edge");
        step(5);
        scl_i = 1'b1; step(3);
        scl_i = 1'b0;
        exp_at(3, 3'b110, "R11 fall after rise starts pull");
        step(3);
        exp_at(1, 3'b000, "R3 window of one tick");
        pulse_tick();

        // R4: clamp with continuous tick
        scl_high();
        arm(17'h1FFFF, 1'b0);
        us_tick_i = 1'b1;
        step(3);
        scl_i = 1'b0;
        step(3);
        begin
            int n = 0;
            while (sda_pull_o && n < 150000) begin
                n++;
                @(negedge clk);
            end
            total++;
            if (n != MAX_US) begin
                bad++;
                $display("FAIL R4 clamped window length got=%0d exp=%0d", n, MAX_US);
            end
        end
        chk({sda_pull_o, active_o, trig_o}, 3'b000, "R4 R10 released after clamp");
        us_tick_i = 1'b0;
        step(3);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule